// File: doc/BRIEF.md
# Serviced Watchdog Timer

This block is a bus-programmed watchdog that raises a system reset request when a down-counter runs out. Software reaches three 16-bit registers through a small single-cycle bus slave: a control register, a timeout register and a count register. The normal setup is:

1. Disable the watchdog.
2. Load the timeout.
3. Enable it.

Enabling copies the timeout into the counter. The counter then counts down on every cycle in which the tick-enable input is high. This input stands in for a slow oscillator.

To keep the system alive, software must service the watchdog by writing two fixed words to the count register in a fixed order. Only that exact pair reloads the counter. Any other write to the count register cancels a half-finished sequence.

Two lock bits make parts of the configuration write-once until the next reset. One lock freezes the control register. The other freezes the timeout register.

When the counter is at zero and one more tick arrives while enabled, the reset request goes high. It stays high until the block itself is reset.

Top module: `svc_watchdog`

## Requirements
- R1: After reset the control, timeout and count registers read 0, and `wdt_reset_req` and `bus_ack` are low.
- R2: Every bus access with `bus_cyc` and `bus_stb` high is acknowledged by a one-cycle `bus_ack` on the next cycle, with read data valid in that same cycle. Word offset 0 is control, 1 is timeout and 2 is count, which reads the live counter value. Offset 3 reads 0 and ignores writes.
- R3: The control register fields are:
  - bit 0: enable
  - bit 1: control lock
  - bit 2: timeout lock
  
  Reads return these three bits, with all other bits 0.
- R4: A control write that changes enable from 0 to 1 loads the counter from the timeout register. A write that leaves enable at 1 does not reload.
- R5: While enabled, the counter decreases by exactly one on each clock cycle in which `tick_en` is high. It holds its value while disabled or while `tick_en` is low.
- R6: A tick while enabled with the counter at 0 raises `wdt_reset_req` on the next cycle. A timeout of T therefore expires on the (T+1)-th tick after loading.
- R7: Once raised, `wdt_reset_req` stays high and the counter stops decrementing until `rst_n` is taken low.
- R8: Writing 0x5555 and then 0xAAAA to the count register reloads the counter from the timeout register. The reload wins over a tick in the same cycle.
- R9: The service tracker works as follows:
  - A count-register write of any value other than 0x5555 clears the tracker.
  - 0xAAAA without a pending 0x5555 does not reload.
  - Writes to the other registers leave the tracker unchanged.
- R10: Once the control lock bit is set, control writes are acknowledged but change nothing until reset.
- R11: Lock bits, once set, cannot be cleared by software. While the timeout lock is set, timeout writes are acknowledged but ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count-down strobe, one decrement per high cycle |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Write (1) or read (0) |
| bus_adr | input | 2 | Register word offset |
| bus_wdat | input | DATA_W | Write data |
| bus_rdat | output | DATA_W | Registered read data |
| bus_ack | output | 1 | One-cycle acknowledge |
| wdt_reset_req | output | 1 | Sticky system reset request |

## Verification
The bench builds the block with a 16-bit data path and an 8-bit counter (`CNT_W = 8`). This makes every timeout value from 0 to 255 reachable, each run to expiry in a few hundred cycles. The expiry point, the midpoint count and the stickiness of the reset request are therefore checked for the full counter range rather than for samples.

The service tracker is swept over all ordered pairs drawn from the two service words and two near-miss words. Further checks cover:
- a tracker that spans a write to another register;
- a reload colliding with a tick;
- every control value written after the control lock is set.

// File: rtl/wdog_pkg.sv
// Shared definitions for the serviced watchdog: register offsets,
// control bit positions and the two service words.
package wdog_pkg;

    typedef enum logic [1:0] {
        ADR_CTRL = 2'd0,
        ADR_TMO  = 2'd1,
        ADR_CNT  = 2'd2,
        ADR_NONE = 2'd3
    } reg_sel_e;

    localparam int CTRL_RUN_BIT   = 0;
    localparam int CTRL_LOCKC_BIT = 1;
    localparam int CTRL_LOCKT_BIT = 2;

    localparam logic [15:0] SVC_ARM_WORD  = 16'h5555;
    localparam logic [15:0] SVC_FIRE_WORD = 16'hAAAA;

    typedef struct packed {
        logic lock_tmo;
        logic lock_ctl;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/wdog_bus_if.sv
// Bus slave front end. Decodes an access, returns a one-cycle
// acknowledge on the following cycle and registers read data from the
// mux of register views. Assumes the master holds a request until it
// sees the acknowledge, and then drops it.
module wdog_bus_if
    import wdog_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc,
    input  logic              stb,
    input  logic              we,
    input  logic [1:0]        adr,
    input  logic [DATA_W-1:0] ctrl_rd,
    input  logic [DATA_W-1:0] tmo_rd,
    input  logic [DATA_W-1:0] cnt_rd,
    output logic              ack,
    output logic [DATA_W-1:0] rdat,
    output logic              wr_en,
    output reg_sel_e          wr_sel
);

    logic              req;
    logic [DATA_W-1:0] rd_mux;

    // An access is new only while no acknowledge is outstanding.
    assign req    = cyc & stb & ~ack;
    assign wr_en  = req & we;
    assign wr_sel = reg_sel_e'(adr);

    // Select the register view addressed by the bus.
    always_comb begin
        unique case (reg_sel_e'(adr))
            ADR_CTRL: rd_mux = ctrl_rd;
            ADR_TMO:  rd_mux = tmo_rd;
            ADR_CNT:  rd_mux = cnt_rd;
            default:  rd_mux = '0;
        endcase
    end

    // Register the acknowledge and the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack  <= 1'b0;
            rdat <= '0;
        end else begin
            ack <= req;
            if (req && !we) begin
                rdat <= rd_mux;
            end
        end
    end

endmodule

// File: rtl/wdog_cfg_regs.sv
// Control and timeout registers with write-once locks. Emits a load
// pulse when a control write turns the enable bit from 0 to 1.
// Assumes CNT_W <= DATA_W.
module wdog_cfg_regs
    import wdog_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  timeout,
    output logic              en_load,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic [DATA_W-1:0] tmo_rd
);

    logic ctrl_wr;
    logic tmo_wr;

    assign ctrl_wr = wr_en && (wr_sel == ADR_CTRL) && !ctrl.lock_ctl;
    assign tmo_wr  = wr_en && (wr_sel == ADR_TMO) && !ctrl.lock_tmo;
    assign en_load = ctrl_wr && wr_data[CTRL_RUN_BIT] && !ctrl.run;

    // Update the control fields; lock bits can only be set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl.run      <= wr_data[CTRL_RUN_BIT];
            ctrl.lock_ctl <= wr_data[CTRL_LOCKC_BIT];
            ctrl.lock_tmo <= ctrl.lock_tmo | wr_data[CTRL_LOCKT_BIT];
        end
    end

    // Hold the timeout value unless its lock is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout <= '0;
        end else if (tmo_wr) begin
            timeout <= wr_data[CNT_W-1:0];
        end
    end

    // Zero-extended read views.
    always_comb begin
        ctrl_rd                 = '0;
        ctrl_rd[CTRL_RUN_BIT]   = ctrl.run;
        ctrl_rd[CTRL_LOCKC_BIT] = ctrl.lock_ctl;
        ctrl_rd[CTRL_LOCKT_BIT] = ctrl.lock_tmo;
        tmo_rd                  = '0;
        tmo_rd[CNT_W-1:0]       = timeout;
    end

endmodule

// File: rtl/wdog_svc_seq.sv
// Service-sequence tracker. Arms on the first service word written to
// the count register and fires a reload on the second one if armed.
// Any other count-register write disarms. Other registers are ignored.
module wdog_svc_seq
    import wdog_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              svc_reload
);

    localparam logic [DATA_W-1:0] ARM_W  = DATA_W'(SVC_ARM_WORD);
    localparam logic [DATA_W-1:0] FIRE_W = DATA_W'(SVC_FIRE_WORD);

    logic cnt_wr;
    logic armed;

    assign cnt_wr     = wr_en && (wr_sel == ADR_CNT);
    assign svc_reload = cnt_wr && armed && (wr_data == FIRE_W);

    // Track whether the first service word was the last count write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (cnt_wr) begin
            armed <= (wr_data == ARM_W);
        end
    end

endmodule

// File: rtl/wdog_down_ctr.sv
// Down-counter and sticky expiry flag. Load has priority over a tick.
// A tick at zero while running sets the flag, which holds until reset
// and stops further counting.
module wdog_down_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             expired
);

    logic at_zero;

    assign at_zero = (count == '0);

    // Reload, decrement or expire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            expired <= 1'b0;
        end else if (load) begin
            count <= load_val;
        end else if (run && tick && !expired) begin
            if (at_zero) begin
                expired <= 1'b1;
            end else begin
                count <= count - 1'b1;
            end
        end
    end

endmodule

// File: rtl/svc_watchdog.sv
// Top level of the serviced watchdog: bus slave, configuration
// registers, service tracker and down-counter. Assumes CNT_W <= DATA_W
// and DATA_W >= 16, so that the service words fit.
module svc_watchdog
    import wdog_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_cyc,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [1:0]        bus_adr,
    input  logic [DATA_W-1:0] bus_wdat,
    output logic [DATA_W-1:0] bus_rdat,
    output logic              bus_ack,
    output logic              wdt_reset_req
);

    logic              wr_en;
    reg_sel_e          wr_sel;
    ctrl_t             ctrl;
    logic [CNT_W-1:0]  timeout;
    logic [CNT_W-1:0]  count;
    logic              en_load;
    logic              svc_reload;
    logic              ctr_load;
    logic              run;
    logic              lock_ctl;
    logic              lock_tmo;
    logic [DATA_W-1:0] ctrl_rd;
    logic [DATA_W-1:0] tmo_rd;
    logic [DATA_W-1:0] cnt_rd;

    assign ctr_load = en_load | svc_reload;
    assign run      = ctrl.run;
    assign lock_ctl = ctrl.lock_ctl;
    assign lock_tmo = ctrl.lock_tmo;

    // Zero-extend the live count for reads.
    always_comb begin
        cnt_rd            = '0;
        cnt_rd[CNT_W-1:0] = count;
    end

    wdog_bus_if #(.DATA_W(DATA_W)) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc     (bus_cyc),
        .stb     (bus_stb),
        .we      (bus_we),
        .adr     (bus_adr),
        .ctrl_rd (ctrl_rd),
        .tmo_rd  (tmo_rd),
        .cnt_rd  (cnt_rd),
        .ack     (bus_ack),
        .rdat    (bus_rdat),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel)
    );

    wdog_cfg_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (bus_wdat),
        .ctrl    (ctrl),
        .timeout (timeout),
        .en_load (en_load),
        .ctrl_rd (ctrl_rd),
        .tmo_rd  (tmo_rd)
    );

    wdog_svc_seq #(.DATA_W(DATA_W)) u_svc (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (bus_wdat),
        .svc_reload (svc_reload)
    );

    wdog_down_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl.run),
        .tick     (tick_en),
        .load     (ctr_load),
        .load_val (timeout),
        .count    (count),
        .expired  (wdt_reset_req)
    );

endmodule

// File: rtl/svc_watchdog_chk.sv
// Temporal checks on the serviced watchdog, attached by bind.
module svc_watchdog_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic             alarm,
    input logic             run,
    input logic             lock_ctl,
    input logic             lock_tmo,
    input logic             tick,
    input logic             load,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] timeout
);

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R2
    AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> count == timeout); // R4
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !alarm && !load && count != '0) |=> count == $past(count) - 1'b1); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(count)); // R5
    AST_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && count == '0) |=> alarm); // R6
    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |=> alarm); // R7
    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(timeout)); // R8
    AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        lock_ctl |=> lock_ctl && $stable(run) && $stable(lock_tmo)); // R10
    AST_TMO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        lock_tmo |=> lock_tmo && $stable(timeout)); // R11

endmodule

bind svc_watchdog svc_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (bus_ack),
    .alarm    (wdt_reset_req),
    .run      (run),
    .lock_ctl (lock_ctl),
    .lock_tmo (lock_tmo),
    .tick     (tick_en),
    .load     (ctr_load),
    .count    (count),
    .timeout  (timeout)
);

// File: tb/svc_watchdog_bench.sv
// Self-checking bench for the serviced watchdog, 8-bit counter build.
module svc_watchdog_bench;

    localparam int DW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          cyc = 1'b0;
    logic          stb = 1'b0;
    logic          we = 1'b0;
    logic [1:0]    adr = 2'd0;
    logic [DW-1:0] wdat = '0;
    logic [DW-1:0] rdat;
    logic          ack;
    logic          rreq;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    svc_watchdog #(.DATA_W(DW), .CNT_W(CW)) u_svc_watchdog (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_en       (tick),
        .bus_cyc       (cyc),
        .bus_stb       (stb),
        .bus_we        (we),
        .bus_adr       (adr),
        .bus_wdat      (wdat),
        .bus_rdat      (rdat),
        .bus_ack       (ack),
        .wdt_reset_req (rreq)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_op(input logic wr, input logic [1:0] a, input logic [DW-1:0] d,
                          input logic tk, output int rd);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = wr; adr = a; wdat = d; tick = tk;
        @(negedge clk);
        rd = int'(rdat);
        check("R2", "ack", int'(ack), 1);
        cyc = 1'b0; stb = 1'b0; we = 1'b0; tick = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input int d);
        int dummy;
        bus_op(1'b1, a, DW'(d), 1'b0, dummy);
    endtask

    task automatic rd_reg(input logic [1:0] a, output int v);
        bus_op(1'b0, a, '0, 1'b0, v);
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    // Watchdog on the bench itself.
    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int v;
        int dummy;

        // R1: reset state.
        do_reset();
        @(negedge clk);
        check("R1", "ack idle", int'(ack), 0);
        check("R1", "reset req", int'(rreq), 0);
        rd_reg(2'd0, v); check("R1", "ctrl", v, 0);
        rd_reg(2'd1, v); check("R1", "timeout", v, 0);
        rd_reg(2'd2, v); check("R1", "count", v, 0);
        wr_reg(2'd3, 16'hFFFF);
        rd_reg(2'd3, v); check("R2", "offset 3", v, 0);

        // R4 R5 R6 R7: every timeout value run to expiry.
        for (int t = 0; t < (1 << CW); t++) begin
            do_reset();
            wr_reg(2'd1, t);
            wr_reg(2'd0, 1);
            rd_reg(2'd2, v); check("R4", "loaded", v, t);
            ticks(t / 2);
            rd_reg(2'd2, v); check("R5", "midpoint", v, t - t / 2);
            ticks(t - t / 2);
            rd_reg(2'd2, v); check("R5", "at zero", v, 0);
            check("R6", "no early expiry", int'(rreq), 0);
            ticks(1);
            check("R6", "expired", int'(rreq), 1);
            ticks(3);
            check("R7", "sticky", int'(rreq), 1);
            rd_reg(2'd2, v); check("R7", "count stopped", v, 0);
        end
        do_reset();
        @(negedge clk);
        check("R7", "cleared by reset", int'(rreq), 0);

        // R5 R4 R3: hold while disabled, reload on re-enable.
        wr_reg(2'd1, 50);
        wr_reg(2'd0, 1);
        rd_reg(2'd0, v); check("R3", "ctrl enable bit", v, 1);
        ticks(5);
        rd_reg(2'd2, v); check("R5", "after 5 ticks", v, 45);
        wr_reg(2'd0, 0);
        ticks(10);
        rd_reg(2'd2, v); check("R5", "hold while disabled", v, 45);
        wr_reg(2'd0, 1);
        rd_reg(2'd2, v); check("R4", "reload on enable", v, 50);
        repeat (10) @(negedge clk);
        rd_reg(2'd2, v); check("R5", "hold without tick", v, 50);
        wr_reg(2'd1, 70);
        wr_reg(2'd0, 1);
        rd_reg(2'd2, v); check("R4", "no reload when already on", v, 50);

        // R8 R9: ordered pairs of count-register writes.
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                int words [4] = '{16'h5555, 16'hAAAA, 16'h1234, 16'h5554};
                int exp;
                do_reset();
                wr_reg(2'd1, 40);
                wr_reg(2'd0, 1);
                ticks(10);
                wr_reg(2'd2, words[i]);
                wr_reg(2'd2, words[j]);
                rd_reg(2'd2, v);
                exp = (i == 0 && j == 1) ? 40 : 30;
                if (exp == 40) check("R8", "service pair", v, exp);
                else check("R9", "no reload", v, exp);
            end
        end

        // R9: tracker survives other writes, cleared by wrong count word.
        do_reset();
        wr_reg(2'd1, 40);
        wr_reg(2'd0, 1);
        ticks(10);
        wr_reg(2'd2, 16'h5555);
        wr_reg(2'd1, 60);
        wr_reg(2'd2, 16'hAAAA);
        rd_reg(2'd2, v); check("R9", "armed across timeout write", v, 60);
        ticks(4);
        wr_reg(2'd2, 16'h5555);
        wr_reg(2'd2, 16'h1234);
        wr_reg(2'd2, 16'hAAAA);
        rd_reg(2'd2, v); check("R9", "tracker cleared", v, 56);

        // R8: reload beats a tick in the same cycle.
        wr_reg(2'd2, 16'h5555);
        bus_op(1'b1, 2'd2, 16'hAAAA, 1'b1, dummy);
        rd_reg(2'd2, v); check("R8", "reload over tick", v, 60);

        // R10: control lock freezes every control value.
        do_reset();
        wr_reg(2'd1, 30);
        wr_reg(2'd0, 3);
        rd_reg(2'd0, v); check("R10", "lock set", v, 3);
        for (int d = 0; d < 8; d++) begin
            wr_reg(2'd0, d);
            rd_reg(2'd0, v); check("R10", "ctrl frozen", v, 3);
        end
        ticks(5);
        rd_reg(2'd2, v); check("R10", "still running", v, 25);
        wr_reg(2'd1, 7);
        rd_reg(2'd1, v); check("R10", "timeout unlocked", v, 7);
        do_reset();
        rd_reg(2'd0, v); check("R10", "lock cleared by reset", v, 0);

        // R11: timeout lock.
        wr_reg(2'd1, 17);
        wr_reg(2'd0, 4);
        wr_reg(2'd0, 0);
        rd_reg(2'd0, v); check("R11", "lock sticky", v, 4);
        wr_reg(2'd1, 99);
        rd_reg(2'd1, v); check("R11", "timeout frozen", v, 17);
        wr_reg(2'd0, 1);
        rd_reg(2'd0, v); check("R11", "enable still allowed", v, 5);
        rd_reg(2'd2, v); check("R11", "loads locked timeout", v, 17);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule